// File: doc/BRIEF.md
# Half-Step Verified Round Datapath

An iterative 128-bit block-transform engine that defends itself against injected faults. Every round is split into two half-steps, and each half-step takes one clock. After each half-step the engine undoes it with the matching inverse transform. It then compares the recovered value with a shadow copy of the value that existed before the step. At the end of the run, the engine compares the round key it has derived with a reference final key supplied by the caller. Ciphertext leaves the block only when every comparison in the run has matched.

The half-step transforms and the key advance are simple invertible placeholders. Half-step A XORs in the round key and then rotates. Half-step B rotates and then adds the round key. A run is launched by a start strobe while the engine is idle. The result and the status flags stay stable until the next accepted start. A fault-injection input XORs a mask into the working value whenever a half-step result is written. This lets a test environment model a disturbed register.

Top module: `halfstep_guard`

## Requirements
- R1: The clock edge that accepts `start_i` loads the working value with `plain_i ^ key_i`, loads the key register with `key_i` and loads the reference register with `final_key_i`.
- R2: A run has 10 rounds, and each round takes two half-step edges. `done_o` is low before the 21st edge after the accepted start and high from that edge on. `done_o` and an active run never coincide.
- R3: The round constant is c(r) = r placed at bit 0 and again at bit 64. With a fault-free run and a matching reference key, `cipher_o` equals the model result, computed as follows. Start with D = P^K. For r = 1..10: first K = rol(K,11) ^ c(r); then D = rol(D^K,7); then D = rol(D,29) + K (mod 2^128).
- R4: A nonzero `upset_i` during any of the 20 half-step edges sets `err_step_o` by the end of the run. This holds for every half-step position.
- R5: If the round key after round 10 differs from the captured reference key, `err_key_o` is set on the 21st edge.
- R6: When either error flag is set, `cipher_o` is all zeros and `done_o` still rises on the 21st edge.
- R7: The error flags and `done_o` hold their values until the next accepted start, which clears them.
- R8: A start strobe during an active run is ignored. The run finishes with the result of the data captured at its own start.
- R9: Reset clears the working, shadow, key and reference registers, both error flags and `done_o`.
- R10: `cipher_o` is all zeros whenever `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a run when idle |
| plain_i | input | 128 | Plaintext block |
| key_i | input | 128 | Master key |
| final_key_i | input | 128 | Expected round key after the last round |
| upset_i | input | 128 | Fault mask XORed into each half-step result |
| cipher_o | output | 128 | Released result, zero unless valid |
| done_o | output | 1 | Run finished, held until next start |
| err_step_o | output | 1 | A half-step back-check mismatched |
| err_key_o | output | 1 | Final round key mismatched the reference |

## Verification
The accepted start edge counts as edge 0. Half-steps occur on edges 1 through 20. A half-step taken on edge k is back-checked on edge k+1. The final key comparison and `done_o` fall due on edge 21. The bench drives every input on falling edges. It counts falling edges from the start, so that a fault mask is present for exactly the rising edge of the chosen half-step. Status is read just after edge 20, where `done_o` must still be low, and just after edge 21, where all results are due.

// File: rtl/hsv_pkg.sv
package hsv_pkg;
   typedef enum logic [0:0] {
      HALF_A = 1'b0,
      HALF_B = 1'b1
   } half_e;

   localparam int unsigned RND_W = 8;
endpackage

// File: rtl/hsv_half.sv
module hsv_half #(
   parameter int unsigned W       = 128,
   parameter int unsigned ROT     = 7,
   parameter bit          MIX_ADD = 1'b0
) (
   input  logic [W-1:0] x_i,
   input  logic [W-1:0] kf_i,
   input  logic [W-1:0] y_i,
   input  logic [W-1:0] ki_i,
   output logic [W-1:0] fwd_o,
   output logic [W-1:0] inv_o
);
   if (ROT == 0 || ROT >= W) begin : g_bad_rot
      $error("hsv_half: ROT must lie in 1..W-1");
   end

   if (MIX_ADD == 1'b0) begin : g_xor_rot
      logic [W-1:0] mixed;
      logic [W-1:0] unrot;
      always_comb begin
         mixed = x_i ^ kf_i;
         fwd_o = {mixed[W-1-ROT:0], mixed[W-1:W-ROT]};
         unrot = {y_i[ROT-1:0], y_i[W-1:ROT]};
         inv_o = unrot ^ ki_i;
      end
   end else begin : g_rot_add
      logic [W-1:0] rot;
      logic [W-1:0] diff;
      always_comb begin
         rot   = {x_i[W-1-ROT:0], x_i[W-1:W-ROT]};
         fwd_o = rot + kf_i;
         diff  = y_i - ki_i;
         inv_o = {diff[ROT-1:0], diff[W-1:ROT]};
      end
   end
endmodule

// File: rtl/hsv_keystep.sv
module hsv_keystep #(
   parameter int unsigned W   = 128,
   parameter int unsigned ROT = 11,
   parameter int unsigned RW  = 8
) (
   input  logic [W-1:0]  k_i,
   input  logic [RW-1:0] rnd_i,
   output logic [W-1:0]  k_o
);
   localparam int unsigned HALF = W / 2;

   if (ROT == 0 || ROT >= W) begin : g_bad_rot
      $error("hsv_keystep: ROT must lie in 1..W-1");
   end
   if (RW > HALF) begin : g_bad_rw
      $error("hsv_keystep: round index wider than half the word");
   end

   logic [W-1:0] rc;
   logic [W-1:0] rot;

   always_comb begin
      rc              = '0;
      rc[RW-1:0]      = rnd_i;
      rc[HALF +: RW]  = rnd_i;
      rot             = {k_i[W-1-ROT:0], k_i[W-1:W-ROT]};
      k_o             = rot ^ rc;
   end
endmodule

// File: rtl/hsv_ctrl.sv
module hsv_ctrl
   import hsv_pkg::*;
#(
   parameter int unsigned ROUNDS = 10,
   parameter int unsigned RW     = 8
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          start_i,
   output logic          accept_o,
   output logic          busy_o,
   output logic          step_o,
   output half_e         half_o,
   output logic [RW-1:0] rnd_o,
   output logic          check_o,
   output half_e         last_half_o,
   output logic          final_o
);
   localparam int unsigned STEPS = 2 * ROUNDS;
   localparam int unsigned CW    = $clog2(STEPS + 1);

   if (ROUNDS == 0) begin : g_bad_rounds
      $error("hsv_ctrl: ROUNDS must be at least 1");
   end
   if (ROUNDS >= (1 << RW)) begin : g_bad_rw
      $error("hsv_ctrl: round index does not fit RW bits");
   end

   logic [CW-1:0] cnt_q;
   logic          busy_q;
   logic          pend_q;
   half_e         last_half_q;

   always_comb begin
      accept_o    = start_i && !busy_q;
      busy_o      = busy_q;
      step_o      = busy_q && (cnt_q < CW'(STEPS));
      final_o     = busy_q && (cnt_q == CW'(STEPS));
      half_o      = cnt_q[0] ? HALF_B : HALF_A;
      rnd_o       = RW'(cnt_q >> 1) + RW'(1);
      check_o     = pend_q;
      last_half_o = last_half_q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q       <= '0;
         busy_q      <= 1'b0;
         pend_q      <= 1'b0;
         last_half_q <= HALF_A;
      end else begin
         pend_q <= step_o;
         if (step_o) begin
            last_half_q <= half_o;
         end
         if (accept_o) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
         end else if (final_o) begin
            busy_q <= 1'b0;
         end else if (busy_q) begin
            cnt_q <= cnt_q + CW'(1);
         end
      end
   end
endmodule

// File: rtl/halfstep_guard.sv
module halfstep_guard
   import hsv_pkg::*;
#(
   parameter int unsigned W       = 128,
   parameter int unsigned ROUNDS  = 10,
   parameter int unsigned ROT_A   = 7,
   parameter int unsigned ROT_B   = 29,
   parameter int unsigned KEY_ROT = 11
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         start_i,
   input  logic [W-1:0] plain_i,
   input  logic [W-1:0] key_i,
   input  logic [W-1:0] final_key_i,
   input  logic [W-1:0] upset_i,
   output logic [W-1:0] cipher_o,
   output logic         done_o,
   output logic         err_step_o,
   output logic         err_key_o
);
   localparam int unsigned RW = RND_W;

   if (W % 2 != 0 || W < 2 * RW) begin : g_bad_width
      $error("halfstep_guard: W must be even and at least twice RND_W");
   end

   logic          accept;
   logic          busy;
   logic          step;
   half_e         half;
   half_e         last_half;
   logic [RW-1:0] rnd;
   logic          check;
   logic          fin;

   logic [W-1:0]  work_q;
   logic [W-1:0]  shadow_q;
   logic [W-1:0]  key_q;
   logic [W-1:0]  ref_q;
   logic          err1_q;
   logic          err2_q;
   logic          done_q;

   logic [W-1:0]  key_adv;
   logic [W-1:0]  fwd_a;
   logic [W-1:0]  inv_a;
   logic [W-1:0]  fwd_b;
   logic [W-1:0]  inv_b;
   logic [W-1:0]  step_val;
   logic [W-1:0]  undo_val;
   logic          mismatch;

   hsv_ctrl #(
      .ROUNDS (ROUNDS),
      .RW     (RW)
   ) u_ctrl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .start_i     (start_i),
      .accept_o    (accept),
      .busy_o      (busy),
      .step_o      (step),
      .half_o      (half),
      .rnd_o       (rnd),
      .check_o     (check),
      .last_half_o (last_half),
      .final_o     (fin)
   );

   hsv_keystep #(
      .W   (W),
      .ROT (KEY_ROT),
      .RW  (RW)
   ) u_keystep (
      .k_i   (key_q),
      .rnd_i (rnd),
      .k_o   (key_adv)
   );

   // first half of a round uses the freshly advanced key
   hsv_half #(
      .W       (W),
      .ROT     (ROT_A),
      .MIX_ADD (1'b0)
   ) u_half_a (
      .x_i   (work_q),
      .kf_i  (key_adv),
      .y_i   (work_q),
      .ki_i  (key_q),
      .fwd_o (fwd_a),
      .inv_o (inv_a)
   );

   hsv_half #(
      .W       (W),
      .ROT     (ROT_B),
      .MIX_ADD (1'b1)
   ) u_half_b (
      .x_i   (work_q),
      .kf_i  (key_q),
      .y_i   (work_q),
      .ki_i  (key_q),
      .fwd_o (fwd_b),
      .inv_o (inv_b)
   );

   always_comb begin
      step_val = (half == HALF_A) ? fwd_a : fwd_b;
      undo_val = (last_half == HALF_A) ? inv_a : inv_b;
      mismatch = (undo_val != shadow_q);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         work_q   <= '0;
         shadow_q <= '0;
         key_q    <= '0;
         ref_q    <= '0;
         err1_q   <= 1'b0;
         err2_q   <= 1'b0;
         done_q   <= 1'b0;
      end else if (accept) begin
         work_q <= plain_i ^ key_i;
         key_q  <= key_i;
         ref_q  <= final_key_i;
         err1_q <= 1'b0;
         err2_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         if (step) begin
            shadow_q <= work_q;
            work_q   <= step_val ^ upset_i;
            if (half == HALF_A) begin
               key_q <= key_adv;
            end
         end
         if (check && mismatch) begin
            err1_q <= 1'b1;
         end
         if (fin) begin
            done_q <= 1'b1;
            if (key_q != ref_q) begin
               err2_q <= 1'b1;
            end
         end
      end
   end

   always_comb begin
      cipher_o   = (done_q && !err1_q && !err2_q) ? work_q : '0;
      done_o     = done_q;
      err_step_o = err1_q;
      err_key_o  = err2_q;
   end
endmodule

// File: rtl/hsv_chk.sv
module hsv_chk #(
   parameter int unsigned W = 128
) (
   input logic         clk_i,
   input logic         rst_ni,
   input logic         start_i,
   input logic         busy,
   input logic         fin,
   input logic [W-1:0] cipher_o,
   input logic         done_o,
   input logic         err_step_o,
   input logic         err_key_o
);
   AST_CIPHER_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cipher_o != '0) |-> (done_o && !err_step_o && !err_key_o)); // R10

   AST_ERR_BLANKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_step_o || err_key_o) |-> (cipher_o == '0)); // R6

   AST_STEP_ERR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_step_o && !start_i) |=> err_step_o); // R7

   AST_KEY_ERR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_key_o && !start_i) |=> err_key_o); // R7

   AST_DONE_AFTER_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(done_o) |-> $past(busy)); // R2

   AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !busy); // R2

   AST_RUN_NOT_CUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy && !fin) |=> busy); // R8
endmodule

bind halfstep_guard hsv_chk #(.W(W)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .start_i    (start_i),
   .busy       (busy),
   .fin        (fin),
   .cipher_o   (cipher_o),
   .done_o     (done_o),
   .err_step_o (err_step_o),
   .err_key_o  (err_key_o)
);

// File: tb/halfstep_guard_tb.sv
module halfstep_guard_tb_top;
   localparam int W = 128;

   logic         clk = 1'b0;
   logic         rst_ni = 1'b0;
   logic         start = 1'b0;
   logic [W-1:0] plain = '0;
   logic [W-1:0] key = '0;
   logic [W-1:0] fkey = '0;
   logic [W-1:0] upset = '0;
   logic [W-1:0] cipher;
   logic         done;
   logic         err1;
   logic         err2;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   halfstep_guard dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_ni),
      .start_i     (start),
      .plain_i     (plain),
      .key_i       (key),
      .final_key_i (fkey),
      .upset_i     (upset),
      .cipher_o    (cipher),
      .done_o      (done),
      .err_step_o  (err1),
      .err_key_o   (err2)
   );

   function automatic logic [W-1:0] rol(input logic [W-1:0] x, input int n);
      return (x << n) | (x >> (W - n));
   endfunction

   function automatic logic [W-1:0] rcon(input int r);
      logic [W-1:0] c = '0;
      c[7:0]   = 8'(r);
      c[71:64] = 8'(r);
      return c;
   endfunction

   function automatic logic [W-1:0] model_key(input logic [W-1:0] k);
      logic [W-1:0] kk = k;
      for (int r = 1; r <= 10; r++) kk = rol(kk, 11) ^ rcon(r);
      return kk;
   endfunction

   function automatic logic [W-1:0] model_ct(input logic [W-1:0] p, input logic [W-1:0] k);
      logic [W-1:0] d  = p ^ k;
      logic [W-1:0] kk = k;
      for (int r = 1; r <= 10; r++) begin
         kk = rol(kk, 11) ^ rcon(r);
         d  = rol(d ^ kk, 7);
         d  = rol(d, 29) + kk;
      end
      return d;
   endfunction

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // start on edge 0; optional fault at half-step edge fstep; optional start at edge bstart
   task automatic run(input logic [W-1:0] p, input logic [W-1:0] k, input logic [W-1:0] fk,
                      input int fstep, input logic [W-1:0] mask, input int bstart);
      @(negedge clk);
      plain = p; key = k; fkey = fk; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int c = 1; c <= 21; c++) begin
         if (c == fstep) upset = mask;
         if (c == bstart) begin
            start = 1'b1; plain = ~p; key = ~k; fkey = ~fk;
         end
         if (c == 21) check("R2 done low after edge 20", W'(done), W'(0));
         @(negedge clk);
         upset = '0;
         start = 1'b0;
      end
   endtask

   task automatic expect_clean(input string tag, input logic [W-1:0] p, input logic [W-1:0] k);
      check({tag, " cipher"}, cipher, model_ct(p, k));
      check({tag, " done"}, W'(done), W'(1));
      check({tag, " err_step"}, W'(err1), W'(0));
      check({tag, " err_key"}, W'(err2), W'(0));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] pv [4];
      logic [W-1:0] kv [4];
      pv[0] = '0;                                     kv[0] = '0;
      pv[1] = '1;                                     kv[1] = 128'h0123456789abcdef_fedcba9876543210;
      pv[2] = 128'h3243f6a8885a308d_313198a2e0370734; kv[2] = 128'h2b7e151628aed2a6_abf7158809cf4f3c;
      pv[3] = 128'hdeadbeef_cafef00d_00112233_44556677; kv[3] = pv[3];

      repeat (3) @(negedge clk);
      check("R9 reset cipher", cipher, '0);
      check("R9 reset done", W'(done), W'(0));
      check("R9 reset err_step", W'(err1), W'(0));
      check("R9 reset err_key", W'(err2), W'(0));
      rst_ni = 1'b1;
      @(negedge clk);
      check("R10 idle cipher zero", cipher, '0);

      // fault-free vectors, last one has plaintext equal to key (R1: D0 is zero)
      for (int i = 0; i < 4; i++) begin
         run(pv[i], kv[i], model_key(kv[i]), 0, '0, 0);
         expect_clean(i == 3 ? "R1 R3 equal pt/key" : "R3 clean run", pv[i], kv[i]);
      end

      // results held with no new start
      repeat (4) @(negedge clk);
      check("R7 held cipher", cipher, model_ct(pv[3], kv[3]));
      check("R7 held done", W'(done), W'(1));

      // sweep a single-bit upset over every half-step position
      for (int s = 1; s <= 20; s++) begin
         run(pv[2], kv[2], model_key(kv[2]), s, W'(1) << ((s * 37) % W), 0);
         check("R4 step error raised", W'(err1), W'(1));
         check("R6 cipher blanked", cipher, '0);
         check("R6 done still set", W'(done), W'(1));
         check("R5 key error quiet", W'(err2), W'(0));
      end
      repeat (3) @(negedge clk);
      check("R7 step error held", W'(err1), W'(1));

      // wrong reference key
      run(pv[1], kv[1], model_key(kv[1]) ^ (W'(1) << 90), 0, '0, 0);
      check("R5 key error raised", W'(err2), W'(1));
      check("R5 step error quiet", W'(err1), W'(0));
      check("R6 cipher blanked key", cipher, '0);
      check("R6 done set key", W'(done), W'(1));

      // next start clears the flags
      run(pv[1], kv[1], model_key(kv[1]), 0, '0, 0);
      expect_clean("R7 cleared by start", pv[1], kv[1]);

      // start during a run is ignored
      run(pv[2], kv[2], model_key(kv[2]), 0, '0, 8);
      expect_clean("R8 busy start ignored", pv[2], kv[2]);

      // reset in mid run after an error
      run(pv[0], kv[0], model_key(kv[0]), 5, W'(1) << 3, 0);
      check("R4 pre-reset error", W'(err1), W'(1));
      @(negedge clk);
      plain = pv[1]; key = kv[1]; fkey = model_key(kv[1]); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (6) @(negedge clk);
      rst_ni = 1'b0;
      @(negedge clk);
      check("R9 mid reset err_step", W'(err1), W'(0));
      check("R9 mid reset done", W'(done), W'(0));
      check("R9 mid reset cipher", cipher, '0);
      rst_ni = 1'b1;
      repeat (25) @(negedge clk);
      check("R9 no resume after reset", W'(done), W'(0));

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule